// File: doc/BRIEF.md
# Dual-Channel Tachometer Timer Register Bank

This block is the software-visible register bank of a two-channel tachometer timer. A simple request/response port carries byte-addressed reads and writes. Each register accepts exactly one access width, and a mismatched width or an unmapped offset is answered with an error. The bank stores the control fields that drive the timer core: prescaler, clock enables, mode, compare values, compare configuration and input selects. It also holds four counter and capture registers, which the core loads through dedicated strobes.

Six interrupt sources are kept in a pending register. The core sets them with single-cycle event strobes. Software clears them by writing ones to a write-only clear register, or overwrites them directly. An enable register gates the pending bits, and their combination drives a single registered level interrupt. Reset clears only the control half of the map and leaves the counter and capture values intact.

Top module: `tach_regbank`

## Requirements
- R1: The byte offsets are CNTA 0x00, CAPA 0x02, CAPB 0x04, CNTB 0x06, PSC 0x08, CLKEN 0x0A, MODE 0x0C, PEND 0x0E, PCLR 0x10, PEN 0x12, CMPA 0x14, CMPB 0x16, CMPCFG 0x18, SELA 0x1A and SELB 0x1C.
- R2: CNTA, CAPA, CAPB, CNTB, CMPA and CMPB accept only halfword accesses (`req_size`=1). Every other mapped register accepts only byte accesses (`req_size`=0). A mismatch returns `rsp_err`=1 with read data 0, and a rejected write changes nothing.
- R3: An odd offset, including an unaligned halfword, or any offset above 0x1C returns `rsp_err`=1 and has no effect.
- R4: Every request is answered exactly one cycle later on `rsp_valid`. Data is little-endian: halfword registers return bits 15:0, and byte registers return bits 7:0 with bits 15:8 zero.
- R5: A byte write to PCLR clears every PEND bit whose position is 1 in the written value. A read of PCLR returns 0 without error.
- R6: PEND bits 0 to 5 are the six sources, and `evt_set[i]` sets bit i. PEN uses the same positions as enables. Bits 7:6 of both registers read 0. A byte write to PEND loads bits 5:0 directly.
- R7: `irq` is registered. In the cycle after PEND and PEN share a set bit it is 1, and otherwise it is 0. A change to PEND or PEN therefore reaches `irq` one clock after the register itself changes.
- R8: When `evt_set` sets a bit in the same cycle that a PCLR or PEND write would clear it, the bit ends up set.
- R9: Reset zeroes PSC through SELB and drives `irq` low. CNTA, CAPA, CAPB and CNTB keep their values.
- R10: `core_load[k]` loads halfword k of `core_load_data` into CNTA, CAPA, CAPB or CNTB (k = 0..3). It takes priority over a bus write to the same register in the same cycle.
- R11: The control outputs always equal the contents of PSC, CLKEN, MODE, CMPA, CMPB, CMPCFG, SELA and SELB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_wdata | input | 16 | Write data, byte accesses use bits 7:0 |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 16 | Read data |
| core_load | input | 4 | Load strobes for CNTA, CAPA, CAPB, CNTB |
| core_load_data | input | 64 | Four halfwords, halfword k for register k |
| evt_set | input | 6 | Pending-bit set strobes |
| psc_o | output | 8 | Prescaler field |
| clken_o | output | 8 | Clock enable field |
| mode_o | output | 8 | Mode field |
| cmpa_o | output | 16 | Compare value A |
| cmpb_o | output | 16 | Compare value B |
| cmpcfg_o | output | 8 | Compare configuration |
| sela_o | output | 8 | Input select A |
| selb_o | output | 8 | Input select B |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `req_valid` is low throughout reset. Under that assumption, the first response after reset can only follow a request that was issued after reset. They also assume the core treats `evt_set` as a pulse and never holds a source high during a sweep in which software expects the pending register to stay cleared. The stimulus respects both assumptions: requests begin only after reset is released, and every event is driven for exactly one cycle, apart from the deliberate collision with a clear.

// File: rtl/tach_pkg.sv
package tach_pkg;

    localparam int HW = 16;
    localparam int BW = 8;

    typedef enum logic [3:0] {
        IX_CNTA   = 4'd0,
        IX_CAPA   = 4'd1,
        IX_CAPB   = 4'd2,
        IX_CNTB   = 4'd3,
        IX_PSC    = 4'd4,
        IX_CLKEN  = 4'd5,
        IX_MODE   = 4'd6,
        IX_PEND   = 4'd7,
        IX_PCLR   = 4'd8,
        IX_PEN    = 4'd9,
        IX_CMPA   = 4'd10,
        IX_CMPB   = 4'd11,
        IX_CMPCFG = 4'd12,
        IX_SELA   = 4'd13,
        IX_SELB   = 4'd14,
        IX_NONE   = 4'd15
    } reg_ix_e;

    function automatic logic is_wide(reg_ix_e ix);
        return (ix == IX_CNTA) || (ix == IX_CAPA) || (ix == IX_CAPB) ||
               (ix == IX_CNTB) || (ix == IX_CMPA) || (ix == IX_CMPB);
    endfunction

    typedef struct packed {
        logic [BW-1:0] psc;
        logic [BW-1:0] clken;
        logic [BW-1:0] mode;
        logic [HW-1:0] cmpa;
        logic [HW-1:0] cmpb;
        logic [BW-1:0] cmpcfg;
        logic [BW-1:0] sela;
        logic [BW-1:0] selb;
    } ctl_regs_t;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [HW-1:0] data;
    } rsp_t;

endpackage

// File: rtl/tach_decode.sv
module tach_decode
    import tach_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] addr,
    input  logic          size,
    output reg_ix_e       ix,
    output logic          err
);
    localparam int LAST_IX = int'(IX_SELB);

    logic hit;

    always_comb begin
        hit = (addr[0] == 1'b0) && (int'(addr[AW-1:1]) <= LAST_IX);
        ix  = hit ? reg_ix_e'(addr[4:1]) : IX_NONE;
        err = !hit || (is_wide(ix) != size);
    end

endmodule

// File: rtl/tach_irq.sv
module tach_irq #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_set,
    input  logic            pend_we,
    input  logic [NSRC-1:0] pend_wdata,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] en,
    output logic            irq
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
        logic            irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pend_we) st_d.pend = pend_wdata;
        if (clr_we)  st_d.pend = st_d.pend & ~clr_mask;
        st_d.pend = st_d.pend | evt_set;
        if (en_we)   st_d.en = en_wdata;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign en   = st_q.en;
    assign irq  = st_q.irq;

    // R8: a raised event is visible in the pending register next cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((st_q.pend & $past(evt_set)) == $past(evt_set)));

    // R7: nothing enabled means no interrupt in the following cycle
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |=> !st_q.irq);

    // R7: a pending-and-enabled source raises irq in the following cycle
    p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & st_q.en) != '0) |=> st_q.irq);

endmodule

// File: rtl/tach_regbank.sv
module tach_regbank
    import tach_pkg::*;
#(
    parameter int AW    = 5,
    parameter int NSRC  = 6,
    parameter int NCNT  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_size,
    input  logic [HW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [HW-1:0]      rsp_rdata,
    input  logic [NCNT-1:0]    core_load,
    input  logic [NCNT*HW-1:0] core_load_data,
    input  logic [NSRC-1:0]    evt_set,
    output logic [BW-1:0]      psc_o,
    output logic [BW-1:0]      clken_o,
    output logic [BW-1:0]      mode_o,
    output logic [HW-1:0]      cmpa_o,
    output logic [HW-1:0]      cmpb_o,
    output logic [BW-1:0]      cmpcfg_o,
    output logic [BW-1:0]      sela_o,
    output logic [BW-1:0]      selb_o,
    output logic               irq
);
    localparam int PADW = HW - NSRC;

    reg_ix_e       ix;
    logic          dec_err;
    logic          bus_wr;
    logic [NSRC-1:0] pend, en;
    logic [HW-1:0] cnt_q [NCNT];
    logic [HW-1:0] cnt_d [NCNT];
    ctl_regs_t     ctl_d, ctl_q;
    rsp_t          rsp_d, rsp_q;

    tach_decode #(.AW(AW)) dec_i (
        .addr (req_addr),
        .size (req_size),
        .ix   (ix),
        .err  (dec_err)
    );

    assign bus_wr = req_valid && req_write && !dec_err;

    tach_irq #(.NSRC(NSRC)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set    (evt_set),
        .pend_we    (bus_wr && ix == IX_PEND),
        .pend_wdata (req_wdata[NSRC-1:0]),
        .clr_we     (bus_wr && ix == IX_PCLR),
        .clr_mask   (req_wdata[NSRC-1:0]),
        .en_we      (bus_wr && ix == IX_PEN),
        .en_wdata   (req_wdata[NSRC-1:0]),
        .pend       (pend),
        .en         (en),
        .irq        (irq)
    );

    // Counter and capture registers: loaded by the core, kept over reset
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (core_load[g])
                cnt_d[g] = core_load_data[g*HW +: HW];
            else if (bus_wr && int'(ix) == g)
                cnt_d[g] = req_wdata;
        end
        always_ff @(posedge clk) cnt_q[g] <= cnt_d[g];
    end

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr) begin
            case (ix)
                IX_PSC:    ctl_d.psc    = req_wdata[BW-1:0];
                IX_CLKEN:  ctl_d.clken  = req_wdata[BW-1:0];
                IX_MODE:   ctl_d.mode   = req_wdata[BW-1:0];
                IX_CMPA:   ctl_d.cmpa   = req_wdata;
                IX_CMPB:   ctl_d.cmpb   = req_wdata;
                IX_CMPCFG: ctl_d.cmpcfg = req_wdata[BW-1:0];
                IX_SELA:   ctl_d.sela   = req_wdata[BW-1:0];
                IX_SELB:   ctl_d.selb   = req_wdata[BW-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && dec_err;
        rsp_d.data  = '0;
        if (req_valid && !req_write && !dec_err) begin
            case (ix)
                IX_CNTA, IX_CAPA, IX_CAPB, IX_CNTB:
                           rsp_d.data = cnt_q[ix[1:0]];
                IX_PSC:    rsp_d.data = {{BW{1'b0}}, ctl_q.psc};
                IX_CLKEN:  rsp_d.data = {{BW{1'b0}}, ctl_q.clken};
                IX_MODE:   rsp_d.data = {{BW{1'b0}}, ctl_q.mode};
                IX_PEND:   rsp_d.data = {{PADW{1'b0}}, pend};
                IX_PEN:    rsp_d.data = {{PADW{1'b0}}, en};
                IX_CMPA:   rsp_d.data = ctl_q.cmpa;
                IX_CMPB:   rsp_d.data = ctl_q.cmpb;
                IX_CMPCFG: rsp_d.data = {{BW{1'b0}}, ctl_q.cmpcfg};
                IX_SELA:   rsp_d.data = {{BW{1'b0}}, ctl_q.sela};
                IX_SELB:   rsp_d.data = {{BW{1'b0}}, ctl_q.selb};
                default:   rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            rsp_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;
    assign psc_o     = ctl_q.psc;
    assign clken_o   = ctl_q.clken;
    assign mode_o    = ctl_q.mode;
    assign cmpa_o    = ctl_q.cmpa;
    assign cmpb_o    = ctl_q.cmpb;
    assign cmpcfg_o  = ctl_q.cmpcfg;
    assign sela_o    = ctl_q.sela;
    assign selb_o    = ctl_q.selb;

    // R4: a response only ever follows a request one cycle earlier
    p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R4: every request is answered in the next cycle
    p_req_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: a rejected access returns no data
    p_err_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R5: the clear register reads as zero
    p_pclr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && !req_size && req_addr == AW'(5'h10))
        |-> (rsp_valid && !rsp_err && rsp_rdata == '0));

    // R11: control fields change only through a request
    p_ctl_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable({psc_o, clken_o, mode_o, cmpa_o, cmpb_o,
                                       cmpcfg_o, sela_o, selb_o}));

endmodule

// File: tb/tach_regbank_tb.sv
module tach_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic [3:0]  core_load = '0;
    logic [63:0] core_load_data = '0;
    logic [5:0]  evt_set = '0;
    logic [7:0]  psc_o, clken_o, mode_o, cmpcfg_o, sela_o, selb_o;
    logic [15:0] cmpa_o, cmpb_o;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m [15];

    always #2 clk = ~clk;

    tach_regbank dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .core_load(core_load), .core_load_data(core_load_data), .evt_set(evt_set),
        .psc_o(psc_o), .clken_o(clken_o), .mode_o(mode_o), .cmpa_o(cmpa_o),
        .cmpb_o(cmpb_o), .cmpcfg_o(cmpcfg_o), .sela_o(sela_o), .selb_o(selb_o),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic wide_ix(input int ix);
        return (ix <= 3) || (ix == 10) || (ix == 11);
    endfunction

    function automatic logic exp_err(input logic [4:0] a, input logic sz);
        if (a[0] || a > 5'h1C) return 1'b1;
        return wide_ix(int'(a[4:1])) != sz;
    endfunction

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        return (a[4:1] == 4'd8) ? 16'h0 : m[a[4:1]];
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [15:0] wd);
        int ix = int'(a[4:1]);
        if (ix == 7)       m[7] = wd & 16'h3F;
        else if (ix == 8)  m[7] = m[7] & ~(wd & 16'h3F);
        else if (ix == 9)  m[9] = wd & 16'h3F;
        else if (wide_ix(ix)) m[ix] = wd;
        else               m[ix] = wd & 16'hFF;
    endtask

    task automatic bus(input logic wr, input logic [4:0] a, input logic sz,
                       input logic [15:0] wd, output logic [15:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R4 valid", {31'b0, rsp_valid}, 32'd1);
        rd = rsp_rdata; er = rsp_err;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic er;
        for (int i = 0; i < 15; i++) m[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 irq after reset", {31'b0, irq}, 32'd0);
        chk("R11 psc after reset", {24'b0, psc_o}, 32'd0);

        // Give the counter registers known values (R10 bus path, R1)
        for (int k = 0; k < 4; k++) begin
            bus(1'b1, 5'(2*k), 1'b1, 16'h1000 + 16'(k), rd, er);
            m[k] = 16'h1000 + 16'(k);
        end

        // R2 R3 write sweep over every offset and both sizes
        for (int a = 0; a < 32; a++) begin
            for (int s = 0; s < 2; s++) begin
                logic [15:0] wd = {5'(a), 3'b101, ~5'(a), 3'b011} ^ (s == 1 ? 16'h0 : 16'h5A00);
                bus(1'b1, 5'(a), 1'(s), wd, rd, er);
                chk("R2 R3 write err", {31'b0, er}, {31'b0, exp_err(5'(a), 1'(s))});
                if (!exp_err(5'(a), 1'(s))) model_write(5'(a), wd);
            end
        end

        // R1 R4 R5 R6 read sweep
        for (int a = 0; a < 32; a++) begin
            for (int s = 0; s < 2; s++) begin
                bus(1'b0, 5'(a), 1'(s), 16'h0, rd, er);
                chk("R2 R3 read err", {31'b0, er}, {31'b0, exp_err(5'(a), 1'(s))});
                chk("R1 R4 R5 read data", {16'b0, rd},
                    {16'b0, exp_err(5'(a), 1'(s)) ? 16'h0 : exp_read(5'(a))});
            end
        end

        // R11 control outputs
        chk("R11 psc",    {24'b0, psc_o},    {16'b0, m[4]});
        chk("R11 clken",  {24'b0, clken_o},  {16'b0, m[5]});
        chk("R11 mode",   {24'b0, mode_o},   {16'b0, m[6]});
        chk("R11 cmpa",   {16'b0, cmpa_o},   {16'b0, m[10]});
        chk("R11 cmpb",   {16'b0, cmpb_o},   {16'b0, m[11]});
        chk("R11 cmpcfg", {24'b0, cmpcfg_o}, {16'b0, m[12]});
        chk("R11 sela",   {24'b0, sela_o},   {16'b0, m[13]});
        chk("R11 selb",   {24'b0, selb_o},   {16'b0, m[14]});

        // R6 R7 interrupt sweep per source
        for (int i = 0; i < 6; i++) begin
            bus(1'b1, 5'h12, 1'b0, 16'(1 << i), rd, er);
            bus(1'b1, 5'h10, 1'b0, 16'h3F, rd, er);
            @(negedge clk);
            chk("R7 idle irq", {31'b0, irq}, 32'd0);
            evt_set = 6'(1 << i);
            @(negedge clk);
            evt_set = '0;
            chk("R7 irq registered delay", {31'b0, irq}, 32'd0);
            @(negedge clk);
            chk("R6 R7 irq raised", {31'b0, irq}, 32'd1);
            bus(1'b0, 5'h0E, 1'b0, 16'h0, rd, er);
            chk("R6 pending position", {16'b0, rd}, 32'(1 << i));
            bus(1'b1, 5'h10, 1'b0, 16'(1 << i), rd, er);
            chk("R7 irq one cycle after clear", {31'b0, irq}, 32'd1);
            @(negedge clk);
            chk("R5 R7 irq dropped", {31'b0, irq}, 32'd0);
            // masked source
            bus(1'b1, 5'h12, 1'b0, 16'(~(1 << i) & 6'h3F), rd, er);
            evt_set = 6'(1 << i);
            @(negedge clk);
            evt_set = '0;
            @(negedge clk);
            @(negedge clk);
            chk("R7 masked source", {31'b0, irq}, 32'd0);
            bus(1'b1, 5'h10, 1'b0, 16'h3F, rd, er);
        end

        // R8 set and clear collide
        @(negedge clk);
        evt_set = 6'h04;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h10; req_size = 1'b0; req_wdata = 16'h3F;
        @(negedge clk);
        evt_set = '0; req_valid = 1'b0; req_write = 1'b0;
        bus(1'b0, 5'h0E, 1'b0, 16'h0, rd, er);
        chk("R8 set wins over clear", {16'b0, rd}, 32'h04);
        bus(1'b1, 5'h10, 1'b0, 16'h3F, rd, er);

        // R10 core load vs bus write
        @(negedge clk);
        core_load = 4'b0001; core_load_data = 64'h0000_0000_0000_1234;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h00; req_size = 1'b1; req_wdata = 16'hBEEF;
        @(negedge clk);
        core_load = '0; req_valid = 1'b0; req_write = 1'b0;
        bus(1'b0, 5'h00, 1'b1, 16'h0, rd, er);
        chk("R10 core load priority", {16'b0, rd}, 32'h1234);
        @(negedge clk);
        core_load = 4'b0100; core_load_data = 64'h0000_7777_0000_0000;
        @(negedge clk);
        core_load = '0;
        bus(1'b0, 5'h04, 1'b1, 16'h0, rd, er);
        chk("R10 core load CAPB", {16'b0, rd}, 32'h7777);
        m[0] = 16'h1234; m[2] = 16'h7777;

        // R9 partial reset with an interrupt pending
        bus(1'b1, 5'h12, 1'b0, 16'h3F, rd, er);
        evt_set = 6'h01;
        @(negedge clk);
        evt_set = '0;
        @(negedge clk);
        chk("R9 irq before reset", {31'b0, irq}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 irq low after reset", {31'b0, irq}, 32'd0);
        for (int a = 0; a <= 28; a += 2) begin
            bus(1'b0, 5'(a), wide_ix(a / 2), 16'h0, rd, er);
            chk("R9 reset contents", {16'b0, rd}, {16'b0, (a < 8) ? m[a / 2] : 16'h0});
        end
        chk("R9 R11 cmpa cleared", {16'b0, cmpa_o}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule